// File: doc/BRIEF.md
# Remote Subblock Attraction Buffer

This block sits beside one cluster's slice of an interleaved first-level data cache. Each slice only owns the words whose address maps to its cluster, so a load to another cluster's word has to travel over the memory buses and comes back as a whole remote subblock. The buffer keeps a copy of such subblocks under a tag of its own. Later loads to the same remote data can then be served inside the cluster.

A lookup address is presented at the same time and in the same cycle as it reaches the local slice. One cycle later the buffer's registered hit and selected word are merged with the slice's hit and word. The local slice wins when both hit. A remote response is written in through the fill port. A store broadcast invalidates a matching copy. A flush input empties the whole buffer in one cycle. The buffer is fully associative and replaces entries in arrival order.

Addresses are word addresses. The low cluster field picks the owning cluster. The word-select field just above it picks a word inside a subblock. The tag is every address bit except the word-select field.

Top module: `attract_buf`

## Requirements
- R1: After reset, no entry is valid, rsp_valid is low and no lookup hits in the buffer until a fill has been accepted.
- R2: rsp_valid follows lk_valid by exactly one clock. The buffer hits when a valid entry's tag equals the lookup tag. With the default parameters the tag is {lk_addr[15:3], lk_addr[1:0]}: the word-select bit lk_addr[2] is removed and the cluster bits [1:0] are kept.
- R3: On a buffer hit, the returned word is word k of the stored subblock, where k is the lookup's word-select field. Word k occupies fill_data[k*32 +: 32].
- R4: In the response cycle, rsp_hit = loc_hit or buffer hit. rsp_data equals loc_data whenever loc_hit is high. rsp_from_buf is high only when the buffer hit and loc_hit is low.
- R5: A fill with fill_tag T makes a lookup with tag T, presented in any later cycle, hit with the filled data, as long as no eviction, store or flush has removed it.
- R6: The buffer holds 8 entries. A fill with a tag not already held takes the slot after the previously filled one, wrapping after the eighth. A ninth distinct fill therefore evicts the oldest entry and keeps the other seven.
- R7: A fill whose tag is already held overwrites that entry's data in place. It does not use or advance the replacement slot, so no other entry is evicted.
- R8: flush clears every entry in one clock and resets the replacement slot to the first entry. A fill in the same cycle is discarded.
- R9: A store with st_valid and tag st_tag invalidates the entry holding that tag. If a fill with the same tag arrives in the same cycle, the fill is discarded.
- R10: If a lookup matches the entry that a same-cycle fill writes, the buffer reports a miss for that lookup. The written entry is visible from the next cycle on.
- R11: Addresses that differ only in their cluster bits have different tags and never hit each other's entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | ADDR_W | Lookup word address, shared with the local slice |
| fill_valid | input | 1 | Remote subblock arriving |
| fill_tag | input | TAG_W | Tag of the arriving subblock |
| fill_data | input | SB_WORDS*WORD_W | Subblock words, word k at bits k*WORD_W |
| st_valid | input | 1 | Store broadcast this cycle |
| st_tag | input | TAG_W | Tag of the stored-to subblock |
| flush | input | 1 | Invalidate every entry |
| loc_hit | input | 1 | Local slice hit, in the response cycle |
| loc_data | input | WORD_W | Local slice word, in the response cycle |
| rsp_valid | output | 1 | Response for the lookup of the previous cycle |
| rsp_hit | output | 1 | Merged hit |
| rsp_from_buf | output | 1 | Word was supplied by this buffer |
| rsp_data | output | WORD_W | Merged word |

## Verification
On every cycle, the assertions check several properties. No two valid entries ever match the same tag. A flush leaves nothing valid and resets the slot. The replacement slot only steps by one or returns to the start. Every accepted fill lands in a valid entry. A lookup that races a fill to the same tag never reports a buffer hit. A buffer-supplied response always follows a lookup. Other behaviours can only be shown by the bench's scenarios against its reference model: the arrival order of evictions, in-place refills, the word selected, local-slice priority in the merge, and the separation of cluster tags.

// File: rtl/ab_pkg.sv
package ab_pkg;

    typedef enum logic [1:0] {
        FILL_NONE   = 2'd0,
        FILL_NEW    = 2'd1,
        FILL_UPDATE = 2'd2,
        FILL_DROP   = 2'd3
    } fill_act_e;

endpackage

// File: rtl/ab_tag_match.sv
module ab_tag_match #(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 15
) (
    input  logic [ENTRIES-1:0]            valid,
    input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]              key,
    output logic [ENTRIES-1:0]            match
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == key);
    end
endmodule

// File: rtl/ab_entry_pick.sv
module ab_entry_pick #(
    parameter int ENTRIES  = 8,
    parameter int SB_WORDS = 2,
    parameter int WORD_W   = 32,
    localparam int SEL_W   = $clog2(SB_WORDS),
    localparam int SB_W    = SB_WORDS * WORD_W
) (
    input  logic [ENTRIES-1:0]           sel_oh,
    input  logic [ENTRIES-1:0][SB_W-1:0] data,
    input  logic [SEL_W-1:0]             word_idx,
    output logic [WORD_W-1:0]            word
);
    logic [SB_W-1:0] sb;

    always_comb begin
        sb = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (sel_oh[e]) sb = sb | data[e];
        end
        word = sb[word_idx*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/attract_buf.sv
module attract_buf
    import ab_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int WORD_W   = 32,
    parameter int SB_WORDS = 2,
    parameter int CLUSTERS = 4,
    parameter int ENTRIES  = 8,
    localparam int SEL_W   = $clog2(SB_WORDS),
    localparam int CL_W    = $clog2(CLUSTERS),
    localparam int TAG_W   = ADDR_W - SEL_W,
    localparam int SB_W    = SB_WORDS * WORD_W,
    localparam int PTR_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              fill_valid,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [SB_W-1:0]   fill_data,
    input  logic              st_valid,
    input  logic [TAG_W-1:0]  st_tag,
    input  logic              flush,
    input  logic              loc_hit,
    input  logic [WORD_W-1:0] loc_data,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_from_buf,
    output logic [WORD_W-1:0] rsp_data
);

    typedef struct packed {
        logic [ENTRIES-1:0]            valid;
        logic [ENTRIES-1:0][TAG_W-1:0] tags;
        logic [ENTRIES-1:0][SB_W-1:0]  data;
        logic [PTR_W-1:0]              wr_ptr;
        logic                          rsp_valid;
        logic                          buf_hit;
        logic [WORD_W-1:0]             buf_word;
    } state_t;

    state_t st_q, st_d;

    logic [TAG_W-1:0]   lk_tag;
    logic [SEL_W-1:0]   lk_word;
    logic [ENTRIES-1:0] match_lk, match_st, match_fill;
    logic [ENTRIES-1:0] tgt_oh, lk_eff;
    logic               fill_known, fill_writes;
    fill_act_e          act;
    logic [WORD_W-1:0]  picked_word;

    // tag = address with the word-select field removed, cluster bits kept
    assign lk_tag  = {lk_addr[ADDR_W-1:CL_W+SEL_W], lk_addr[CL_W-1:0]};
    assign lk_word = lk_addr[CL_W+SEL_W-1:CL_W];

    ab_tag_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_match_lk (
        .valid(st_q.valid), .tags(st_q.tags), .key(lk_tag), .match(match_lk)
    );
    ab_tag_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_match_st (
        .valid(st_q.valid), .tags(st_q.tags), .key(st_tag), .match(match_st)
    );
    ab_tag_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_match_fill (
        .valid(st_q.valid), .tags(st_q.tags), .key(fill_tag), .match(match_fill)
    );

    // fill target and action
    always_comb begin
        fill_known = |match_fill;
        for (int e = 0; e < ENTRIES; e++) begin
            tgt_oh[e] = fill_known ? match_fill[e] : (st_q.wr_ptr == PTR_W'(e));
        end
        if (!fill_valid || flush) begin
            act = FILL_NONE;
        end else if (st_valid && (st_tag == fill_tag)) begin
            act = FILL_DROP;
        end else if (fill_known) begin
            act = FILL_UPDATE;
        end else begin
            act = FILL_NEW;
        end
        fill_writes = (act == FILL_NEW) || (act == FILL_UPDATE);
        lk_eff      = match_lk & ~(fill_writes ? tgt_oh : '0);
    end

    ab_entry_pick #(.ENTRIES(ENTRIES), .SB_WORDS(SB_WORDS), .WORD_W(WORD_W)) u_pick (
        .sel_oh(lk_eff), .data(st_q.data), .word_idx(lk_word), .word(picked_word)
    );

    // next state
    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = lk_valid;
        st_d.buf_hit   = lk_valid && (|lk_eff);
        st_d.buf_word  = picked_word;
        if (flush) begin
            st_d.valid  = '0;
            st_d.wr_ptr = '0;
        end else begin
            if (st_valid) st_d.valid = st_q.valid & ~match_st;
            if (fill_writes) begin
                for (int e = 0; e < ENTRIES; e++) begin
                    if (tgt_oh[e]) begin
                        st_d.valid[e] = 1'b1;
                        st_d.tags[e]  = fill_tag;
                        st_d.data[e]  = fill_data;
                    end
                end
            end
            if (act == FILL_NEW) begin
                st_d.wr_ptr = (st_q.wr_ptr == PTR_W'(ENTRIES - 1)) ? '0
                                                                   : st_q.wr_ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // merge with the local slice
    assign rsp_valid    = st_q.rsp_valid;
    assign rsp_hit      = st_q.rsp_valid && (loc_hit || st_q.buf_hit);
    assign rsp_from_buf = st_q.rsp_valid && st_q.buf_hit && !loc_hit;
    assign rsp_data     = loc_hit ? loc_data : st_q.buf_word;

    // R7
    tag_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_lk) && $onehot0(match_fill));

    // R8
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.valid == '0) && (st_q.wr_ptr == '0));

    // R6
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.wr_ptr != $past(st_q.wr_ptr)) |->
            ((st_q.wr_ptr == $past(st_q.wr_ptr) + 1'b1) || (st_q.wr_ptr == '0)));

    // R5
    fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_writes |=> ((st_q.valid & $past(tgt_oh)) != '0));

    // R10
    fill_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && fill_writes && (fill_tag == lk_tag)) |=> !rsp_from_buf);

    // R2
    buf_rsp_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_from_buf |-> $past(lk_valid));

endmodule

// File: tb/sim_attract_buf.sv
module sim_attract_buf;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [15:0] lk_addr = '0;
    logic        fill_valid = 1'b0;
    logic [14:0] fill_tag = '0;
    logic [63:0] fill_data = '0;
    logic        st_valid = 1'b0;
    logic [14:0] st_tag = '0;
    logic        flush = 1'b0;
    logic        loc_hit = 1'b0;
    logic [31:0] loc_data = '0;
    logic        rsp_valid, rsp_hit, rsp_from_buf;
    logic [31:0] rsp_data;

    always #2 clk = ~clk;

    attract_buf u0 (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .fill_valid(fill_valid), .fill_tag(fill_tag), .fill_data(fill_data),
        .st_valid(st_valid), .st_tag(st_tag), .flush(flush),
        .loc_hit(loc_hit), .loc_data(loc_data), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_from_buf(rsp_from_buf), .rsp_data(rsp_data)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model
    bit          m_val [8];
    logic [14:0] m_tag [8];
    logic [63:0] m_data [8];
    int          m_ptr = 0;

    // pending response
    bit          p_valid = 1'b0;
    bit          p_bh = 1'b0;
    logic [31:0] p_bw = '0;
    bit          p_lh = 1'b0;
    logic [31:0] p_ld = '0;
    string       p_req = "R2";

    function automatic logic [14:0] tag_of(logic [15:0] a);
        return {a[15:3], a[1:0]};
    endfunction

    function automatic logic [15:0] mk_addr(logic [14:0] t, bit w);
        return {t[14:2], w, t[1:0]};
    endfunction

    function automatic int m_find(logic [14:0] t);
        for (int e = 0; e < 8; e++) if (m_val[e] && m_tag[e] == t) return e;
        return -1;
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one cycle: check previous response, then apply new stimulus
    task automatic step(bit lv, logic [15:0] la, bit fv, logic [14:0] ft, logic [63:0] fd,
                        bit sv, logic [14:0] stg, bit fl, bit lh, logic [31:0] ld, string req);
        int idx, tgt;
        bit wr;
        @(negedge clk);
        loc_hit  = p_lh;
        loc_data = p_ld;
        #1;
        check(rsp_valid == p_valid, p_req, 64'(rsp_valid), 64'(p_valid));
        check(rsp_hit == (p_valid && (p_lh || p_bh)), p_req, 64'(rsp_hit),
              64'(p_valid && (p_lh || p_bh)));
        check(rsp_from_buf == (p_valid && p_bh && !p_lh), p_req, 64'(rsp_from_buf),
              64'(p_valid && p_bh && !p_lh));
        if (p_valid && (p_lh || p_bh))
            check(rsp_data == (p_lh ? p_ld : p_bw), p_req, 64'(rsp_data),
                  64'(p_lh ? p_ld : p_bw));
        lk_valid = lv; lk_addr = la; fill_valid = fv; fill_tag = ft; fill_data = fd;
        st_valid = sv; st_tag = stg; flush = fl;
        // model: lookup on old state
        idx = m_find(tag_of(la));
        wr  = fv && !fl && !(sv && stg == ft);
        tgt = (m_find(ft) >= 0) ? m_find(ft) : m_ptr;
        p_valid = lv;
        p_bh    = lv && idx >= 0 && !(wr && idx == tgt);
        p_bw    = (idx >= 0) ? (la[2] ? m_data[idx][63:32] : m_data[idx][31:0]) : '0;
        p_lh    = lh;
        p_ld    = ld;
        p_req   = req;
        // model: update
        if (fl) begin
            for (int e = 0; e < 8; e++) m_val[e] = 1'b0;
            m_ptr = 0;
        end else begin
            if (sv && m_find(stg) >= 0) m_val[m_find(stg)] = 1'b0;
            if (wr) begin
                if (m_find(ft) < 0) m_ptr = (m_ptr + 1) % 8;
                m_val[tgt] = 1'b1; m_tag[tgt] = ft; m_data[tgt] = fd;
            end
        end
    endtask

    task automatic idle(string req);
        step(0, '0, 0, '0, '0, 0, '0, 0, 0, '0, req);
    endtask
    task automatic look(logic [15:0] a, string req);
        step(1, a, 0, '0, '0, 0, '0, 0, 0, '0, req);
    endtask
    task automatic fill(logic [14:0] t, logic [63:0] d, string req);
        step(0, '0, 1, t, d, 0, '0, 0, 0, '0, req);
    endtask

    initial begin
        logic [14:0] ta, tb;
        for (int e = 0; e < 8; e++) begin m_val[e] = 0; m_tag[e] = '0; m_data[e] = '0; end
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1 reset state
        check(rsp_valid == 1'b0, "R1", 64'(rsp_valid), 0);
        check(rsp_hit == 1'b0, "R1", 64'(rsp_hit), 0);
        look(16'h0000, "R1");
        look(16'h1234, "R1");
        // R5 / R3 fill then both words
        ta = 15'h0123;
        fill(ta, 64'hBBBB_0001_AAAA_0001, "R5");
        look(mk_addr(ta, 0), "R5");
        look(mk_addr(ta, 1), "R3");
        // R4 local priority and local-only hit
        step(1, mk_addr(ta, 0), 0, '0, '0, 0, '0, 0, 1, 32'hC0DE_0001, "R4");
        step(1, 16'h7770, 0, '0, '0, 0, '0, 0, 1, 32'hC0DE_0002, "R4");
        // R11 cluster bits separate tags
        tb = {ta[14:2], 2'b10};
        look(mk_addr(tb, 0), "R11");
        fill(tb, 64'hDDDD_0002_CCCC_0002, "R11");
        look(mk_addr(ta, 1), "R11");
        look(mk_addr(tb, 1), "R11");
        // R8 flush, then flush with fill
        step(0, '0, 0, '0, '0, 0, '0, 1, 0, '0, "R8");
        look(mk_addr(ta, 0), "R8");
        step(0, '0, 1, ta, 64'h1, 0, '0, 1, 0, '0, "R8");
        look(mk_addr(ta, 0), "R8");
        // R6 nine distinct fills evict the oldest
        for (int i = 0; i < 9; i++) fill(15'(16 + i * 4), {32'(i), 32'(i + 100)}, "R6");
        look(mk_addr(15'd16, 0), "R6");
        look(mk_addr(15'd20, 0), "R6");
        look(mk_addr(15'd48, 1), "R6");
        // R7 refill in place, no eviction
        fill(15'd24, 64'hFEED_0007_FEED_0070, "R7");
        look(mk_addr(15'd24, 1), "R7");
        look(mk_addr(15'd20, 0), "R7");
        look(mk_addr(15'd28, 0), "R7");
        // R9 store invalidates; store plus same-tag fill drops the fill
        step(0, '0, 0, '0, '0, 1, 15'd28, 0, 0, '0, "R9");
        look(mk_addr(15'd28, 0), "R9");
        look(mk_addr(15'd32, 0), "R9");
        step(0, '0, 1, 15'h0300, 64'h5, 1, 15'h0300, 0, 0, '0, "R9");
        look(mk_addr(15'h0300, 0), "R9");
        // R10 lookup racing a fill of the same tag
        step(1, mk_addr(15'h0404, 1), 1, 15'h0404, 64'h9999_0000_8888_0000, 0, '0, 0, 0, '0, "R10");
        look(mk_addr(15'h0404, 1), "R10");
        step(1, mk_addr(15'd32, 0), 1, 15'd32, 64'h7, 0, '0, 0, 0, '0, "R10");
        look(mk_addr(15'd32, 0), "R10");
        // R2 constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [14:0] rt;
            int r;
            r  = $urandom % 100;
            rt = {13'($urandom % 5), 2'($urandom % 4)};
            step(($urandom % 4) != 0, mk_addr({13'($urandom % 5), 2'($urandom % 4)}, 1'($urandom)),
                 r < 30, rt, {$urandom, $urandom},
                 (r >= 90) || (r < 3), rt, r == 50,
                 ($urandom % 5) == 0, $urandom, "R2");
        end
        idle("R2");
        idle("R2");
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule